// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block prepares the second operand of an integer ALU. It takes a 32-bit value, a shift kind, a shift amount and the current carry flag. It returns the shifted value together with the shifter carry-out, which the flag logic consumes. The shift amount comes from one of two places: a 5-bit field held in the instruction, or the low byte of a register. A second path builds an immediate operand. It zero-extends an 8-bit constant and rotates it right by an even number of places.

Each operation is presented with a one-cycle valid strobe. The result and carry appear on registered outputs in the next cycle. The control that selects the kind, the amount source and the immediate path is decoded upstream; this block only receives the decoded fields.

Top module: `barrel_operand_shifter`

## Requirements
- R1: After a synchronous active-high reset, out_valid, out_value and out_carry are all zero. out_valid equals in_valid from the previous clock edge, and the result is registered with one cycle of latency.
- R2: Kind code 0 is a left shift and kind code 1 is a logical right shift. Both fill the vacated positions with zeros. For an amount n of 1 to 31, the carry-out is the last bit shifted out: bit 32-n for the left shift and bit n-1 for the right shift.
- R3: Kind code 2 is an arithmetic right shift. The vacated high positions take copies of the original bit 31, and the carry-out is bit n-1.
- R4: Kind code 3 is a rotate right. Bits leaving the low end re-enter at the high end, and the carry-out equals bit 31 of the result.
- R5: Kind code 4 shifts right by exactly one place, whatever the amount. carry_in enters bit 31 and the original bit 0 becomes the carry-out.
- R6: With use_reg_amt low, the amount is imm_amt (0 to 31). With use_reg_amt high, the amount is reg_amt[7:0], and bits 31:8 of reg_amt have no effect.
- R7: For kind codes 0 to 3, an amount of zero passes the value through unchanged, and the carry-out equals carry_in.
- R8: For a logical shift (code 0 or 1) with a register amount of exactly 32, the result is zero. The carry-out is the original bit 0 for the left shift and the original bit 31 for the right shift. For an amount above 32, both the result and the carry-out are zero.
- R9: For an arithmetic right shift by 32 or more, every result bit and the carry-out equal the original bit 31.
- R10: A rotate by a register amount uses that amount modulo 32. A non-zero multiple of 32 leaves the value unchanged, and the carry-out is the original bit 31.
- R11: With imm_mode high, the result is imm_byte zero-extended and rotated right by 2*imm_rot. The shift kind and both amount inputs are ignored. The carry-out is carry_in when imm_rot is 0, and bit 31 of the result otherwise.
- R12: Kind codes 5, 6 and 7 pass the value through unchanged, and the carry-out equals carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_value | input | 32 | Value to shift |
| shift_kind | input | 3 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 one-bit rotate through carry |
| use_reg_amt | input | 1 | Amount source select: 1 = register byte |
| imm_amt | input | 5 | Amount taken from the instruction field |
| reg_amt | input | 32 | Register holding the amount in its low byte |
| carry_in | input | 1 | Current carry flag |
| imm_mode | input | 1 | Select the rotated-immediate path |
| imm_byte | input | 8 | Immediate constant |
| imm_rot | input | 4 | Half of the immediate rotation |
| out_valid | output | 1 | Result strobe |
| out_value | output | 32 | Shifted operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
Each shift kind is tried with single-bit markers at bit 0 and bit 31 and with a dense alternating pattern. The markers show which end fills and which bit becomes the carry, and the alternating pattern catches an off-by-one in the amount. Register amounts are placed at 0, 31, 32, 33 and large values with garbage in the upper bytes, which separates the modulo, saturation and byte-masking rules. The immediate path is driven with shift inputs set to disruptive values, which shows they are ignored. Its zero and non-zero rotations show where the carry comes from.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    K_LSL = 3'd0,
    K_LSR = 3'd1,
    K_ASR = 3'd2,
    K_ROR = 3'd3,
    K_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/shf_amount_sel.sv
module shf_amount_sel #(
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8
) (
  input  logic                 use_reg,
  input  logic [IMM_AMT_W-1:0] imm_amt,
  input  logic [REG_AMT_W-1:0] reg_byte,
  output logic [REG_AMT_W-1:0] amount
);
  localparam int PAD_W = REG_AMT_W - IMM_AMT_W;

  always_comb begin
    if (use_reg) amount = reg_byte;
    else         amount = {{PAD_W{1'b0}}, imm_amt};
  end
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] value,
  input  logic [2:0]        kind,
  input  logic [AMT_W-1:0]  amount,
  input  logic              cin,
  output logic [DATA_W-1:0] result,
  output logic              cout
);
  localparam int ROT_W = $clog2(DATA_W);

  logic [DATA_W:0]     left_t;
  logic [DATA_W:0]     right_t;
  logic [DATA_W:0]     arith_t;
  logic [2*DATA_W-1:0] rot_t;
  logic [ROT_W-1:0]    rot_k;

  always_comb begin
    rot_k   = amount[ROT_W-1:0];
    left_t  = {1'b0, value} << amount;
    right_t = {value, 1'b0} >> amount;
    arith_t = $unsigned($signed({value, 1'b0}) >>> amount);
    rot_t   = {value, value} >> rot_k;
  end

  always_comb begin
    result = value;
    cout   = cin;
    if (kind == K_RRX) begin
      result = {cin, value[DATA_W-1:1]};
      cout   = value[0];
    end else if (amount != '0) begin
      case (kind)
        K_LSL: begin
          result = left_t[DATA_W-1:0];
          cout   = left_t[DATA_W];
        end
        K_LSR: begin
          result = right_t[DATA_W:1];
          cout   = right_t[0];
        end
        K_ASR: begin
          result = arith_t[DATA_W:1];
          cout   = arith_t[0];
        end
        K_ROR: begin
          result = rot_t[DATA_W-1:0];
          cout   = rot_t[DATA_W-1];
        end
        default: begin
          result = value;
          cout   = cin;
        end
      endcase
    end
  end
endmodule

// File: rtl/shf_imm_expand.sv
module shf_imm_expand #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input  logic [BYTE_W-1:0] imm_byte,
  input  logic [ROT_W-1:0]  imm_rot,
  input  logic              cin,
  output logic [DATA_W-1:0] result,
  output logic              cout
);
  localparam int SH_W = ROT_W + 1;

  logic [DATA_W-1:0]   base;
  logic [2*DATA_W-1:0] dbl;
  logic [SH_W-1:0]     sh;

  always_comb begin
    base   = {{(DATA_W-BYTE_W){1'b0}}, imm_byte};
    sh     = {imm_rot, 1'b0};
    dbl    = {base, base} >> sh;
    result = dbl[DATA_W-1:0];
    cout   = (imm_rot == '0) ? cin : dbl[DATA_W-1];
  end
endmodule

// File: rtl/barrel_operand_shifter.sv
module barrel_operand_shifter
  import shf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8,
  parameter int BYTE_W    = 8,
  parameter int ROT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    op_value,
  input  logic [2:0]           shift_kind,
  input  logic                 use_reg_amt,
  input  logic [IMM_AMT_W-1:0] imm_amt,
  input  logic [DATA_W-1:0]    reg_amt,
  input  logic                 carry_in,
  input  logic                 imm_mode,
  input  logic [BYTE_W-1:0]    imm_byte,
  input  logic [ROT_W-1:0]     imm_rot,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_value,
  output logic                 out_carry
);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << REG_AMT_W) - 1);

  logic [REG_AMT_W-1:0] amount;
  logic [DATA_W-1:0]    sh_res, im_res;
  logic                 sh_c, im_c;

  shf_amount_sel #(.IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W)) u_amt (
    .use_reg  (use_reg_amt),
    .imm_amt  (imm_amt),
    .reg_byte (reg_amt[REG_AMT_W-1:0]),
    .amount   (amount)
  );

  shf_core #(.DATA_W(DATA_W), .AMT_W(REG_AMT_W)) u_core (
    .value  (op_value),
    .kind   (shift_kind),
    .amount (amount),
    .cin    (carry_in),
    .result (sh_res),
    .cout   (sh_c)
  );

  shf_imm_expand #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ROT_W(ROT_W)) u_imm (
    .imm_byte (imm_byte),
    .imm_rot  (imm_rot),
    .cin      (carry_in),
    .result   (im_res),
    .cout     (im_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_carry <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_value <= imm_mode ? im_res : sh_res;
        out_carry <= imm_mode ? im_c   : sh_c;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r7_zero_amount: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !imm_mode && shift_kind <= 3'd3 &&
     (use_reg_amt ? ((reg_amt & LOW_MASK) == '0) : (imm_amt == '0)))
    |=> (out_value == $past(op_value) && out_carry == $past(carry_in)));

  a_r3_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !imm_mode && shift_kind == 3'd2)
    |=> out_value[DATA_W-1] == $past(op_value[DATA_W-1]));

  a_r5_carry_through: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !imm_mode && shift_kind == 3'd4)
    |=> (out_value[DATA_W-1] == $past(carry_in) && out_carry == $past(op_value[0])));

  a_r11_no_rotation: assert property (@(posedge clk) disable iff (rst)
    (in_valid && imm_mode && imm_rot == '0)
    |=> (out_value == DATA_W'($past(imm_byte)) && out_carry == $past(carry_in)));

  a_r4_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !imm_mode && shift_kind == 3'd3)
    |=> $countones(out_value) == $countones($past(op_value)));
endmodule

// File: tb/test_barrel_operand_shifter.sv
module test_barrel_operand_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_value = '0;
  logic [2:0]  shift_kind = '0;
  logic        use_reg_amt = 1'b0;
  logic [4:0]  imm_amt = '0;
  logic [31:0] reg_amt = '0;
  logic        carry_in = 1'b0;
  logic        imm_mode = 1'b0;
  logic [7:0]  imm_byte = '0;
  logic [3:0]  imm_rot = '0;
  logic        out_valid;
  logic [31:0] out_value;
  logic        out_carry;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] q_val[$];
  logic        q_c[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  barrel_operand_shifter i_barrel_operand_shifter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_value(op_value),
    .shift_kind(shift_kind), .use_reg_amt(use_reg_amt), .imm_amt(imm_amt),
    .reg_amt(reg_amt), .carry_in(carry_in), .imm_mode(imm_mode),
    .imm_byte(imm_byte), .imm_rot(imm_rot), .out_valid(out_valid),
    .out_value(out_value), .out_carry(out_carry)
  );

  // bit-serial reference model built from the requirements
  task automatic model(input logic [31:0] v, input logic [2:0] k, input int n,
                       input logic c, output logic [31:0] rv, output logic rc);
    rv = v;
    rc = c;
    if (k == 3'd4) begin
      rc = v[0];
      rv = {c, v[31:1]};
    end else if (k <= 3'd3) begin
      for (int i = 0; i < n; i++) begin
        case (k)
          3'd0: begin rc = rv[31]; rv = {rv[30:0], 1'b0}; end
          3'd1: begin rc = rv[0];  rv = {1'b0, rv[31:1]}; end
          3'd2: begin rc = rv[0];  rv = {rv[31], rv[31:1]}; end
          default: begin rv = {rv[0], rv[31:1]}; rc = rv[31]; end
        endcase
      end
    end
  endtask

  task automatic send_shift(input string tag, input logic [31:0] v, input logic [2:0] k,
                            input logic use_reg, input logic [4:0] ia, input logic [31:0] ra,
                            input logic c);
    logic [31:0] ev;
    logic        ec;
    int          n;
    n = use_reg ? int'(ra[7:0]) : int'(ia);
    model(v, k, n, c, ev, ec);
    @(negedge clk);
    in_valid = 1'b1; imm_mode = 1'b0; op_value = v; shift_kind = k;
    use_reg_amt = use_reg; imm_amt = ia; reg_amt = ra; carry_in = c;
    imm_byte = 8'hA5; imm_rot = 4'h7;
    q_val.push_back(ev); q_c.push_back(ec); q_tag.push_back(tag);
  endtask

  task automatic send_imm(input string tag, input logic [7:0] b, input logic [3:0] r,
                          input logic c);
    logic [31:0] ev;
    ev = {24'h0, b};
    for (int i = 0; i < 2 * int'(r); i++) ev = {ev[0], ev[31:1]};
    @(negedge clk);
    in_valid = 1'b1; imm_mode = 1'b1; imm_byte = b; imm_rot = r; carry_in = c;
    op_value = 32'hDEAD_BEEF; shift_kind = 3'd2; use_reg_amt = 1'b1;
    imm_amt = 5'd13; reg_amt = 32'hFFFF_FF07;
    q_val.push_back(ev); q_c.push_back((r == 4'h0) ? c : ev[31]); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compares results against the scoreboard queue
  initial begin
    logic [31:0] ev;
    logic        ec;
    string       t;
    forever begin
      @(negedge clk);
      #1;
      if (!rst && out_valid) begin
        checks++;
        if (q_val.size() == 0) begin
          failures++;
          $display("FAIL R1 unexpected result: actual %h expected none", out_value);
        end else begin
          ev = q_val.pop_front(); ec = q_c.pop_front(); t = q_tag.pop_front();
          if (out_value !== ev || out_carry !== ec) begin
            failures++;
            $display("FAIL %s actual value=%h carry=%b expected value=%h carry=%b",
                     t, out_value, out_carry, ev, ec);
          end
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || out_value !== 32'h0 || out_carry !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset state: actual %b/%h/%b expected 0/0/0", out_valid, out_value, out_carry);
    end
    @(negedge clk); rst = 1'b0;

    // R2 logical shifts with markers and dense pattern
    send_shift("R2 lsl 1 marker31",   32'h8000_0001, 3'd0, 1'b0, 5'd1,  32'h0, 1'b0);
    send_shift("R2 lsl 4 dense",      32'hA5A5_F00F, 3'd0, 1'b0, 5'd4,  32'h0, 1'b0);
    send_shift("R2 lsl 31",           32'h0000_0003, 3'd0, 1'b0, 5'd31, 32'h0, 1'b0);
    send_shift("R2 lsr 1 marker0",    32'h8000_0001, 3'd1, 1'b0, 5'd1,  32'h0, 1'b0);
    send_shift("R2 lsr 7 dense",      32'hA5A5_F0CF, 3'd1, 1'b0, 5'd7,  32'h0, 1'b1);
    // R3 arithmetic right
    send_shift("R3 asr 4 negative",   32'hA000_000C, 3'd2, 1'b0, 5'd4,  32'h0, 1'b0);
    send_shift("R3 asr 3 positive",   32'h7000_0004, 3'd2, 1'b0, 5'd3,  32'h0, 1'b1);
    // R4 rotate
    send_shift("R4 ror 4",            32'h0000_0071, 3'd3, 1'b0, 5'd4,  32'h0, 1'b0);
    send_shift("R4 ror 31",           32'hC000_0002, 3'd3, 1'b0, 5'd31, 32'h0, 1'b0);
    // R5 one-bit through carry, amount ignored
    send_shift("R5 rrx c1",           32'h0000_0002, 3'd4, 1'b0, 5'd9,  32'h0, 1'b1);
    send_shift("R5 rrx c0 reg amt",   32'hFFFF_FFFF, 3'd4, 1'b1, 5'd0,  32'h0000_0040, 1'b0);
    // R7 zero amount
    send_shift("R7 lsl imm 0",        32'h1234_5678, 3'd0, 1'b0, 5'd0,  32'h0, 1'b1);
    send_shift("R7 ror reg 0 hi junk",32'h8765_4321, 3'd3, 1'b1, 5'd5,  32'hFFFF_FF00, 1'b0);
    // R6 register amount, upper bits ignored
    send_shift("R6 lsr reg 4 hi junk",32'hF000_00F8, 3'd1, 1'b1, 5'd1,  32'hABCD_1204, 1'b0);
    send_shift("R6 lsl reg 31",       32'h0000_0003, 3'd0, 1'b1, 5'd2,  32'h5555_551F, 1'b1);
    // R8 logical at and beyond 32
    send_shift("R8 lsl reg 32",       32'h0000_0001, 3'd0, 1'b1, 5'd0,  32'h0000_0020, 1'b0);
    send_shift("R8 lsr reg 32",       32'h8000_0000, 3'd1, 1'b1, 5'd0,  32'h0000_0020, 1'b0);
    send_shift("R8 lsl reg 33",       32'hFFFF_FFFF, 3'd0, 1'b1, 5'd0,  32'h0000_0021, 1'b1);
    send_shift("R8 lsr reg 200",      32'hFFFF_FFFF, 3'd1, 1'b1, 5'd0,  32'h0000_00C8, 1'b1);
    // R9 arithmetic beyond width
    send_shift("R9 asr reg 32 neg",   32'h8000_0000, 3'd2, 1'b1, 5'd0,  32'h0000_0020, 1'b0);
    send_shift("R9 asr reg 255 pos",  32'h7FFF_FFFF, 3'd2, 1'b1, 5'd0,  32'hFFFF_FFFF, 1'b1);
    // R10 rotate modulo
    send_shift("R10 ror reg 32",      32'h8000_0001, 3'd3, 1'b1, 5'd0,  32'h0000_0020, 1'b0);
    send_shift("R10 ror reg 36",      32'h0000_00F1, 3'd3, 1'b1, 5'd0,  32'h0000_0024, 1'b0);
    send_shift("R10 ror reg 64",      32'h7000_0001, 3'd3, 1'b1, 5'd0,  32'h0000_0040, 1'b1);
    // R12 unused kind codes
    send_shift("R12 kind 5",          32'hCAFE_0001, 3'd5, 1'b0, 5'd3,  32'h0, 1'b1);
    send_shift("R12 kind 7",          32'hCAFE_0001, 3'd7, 1'b1, 5'd3,  32'h0000_0004, 1'b0);
    // R11 immediate path
    send_imm("R11 imm rot 0",   8'hFF, 4'h0, 1'b1);
    send_imm("R11 imm rot 1",   8'h03, 4'h1, 1'b0);
    send_imm("R11 imm rot 15",  8'hC1, 4'hF, 1'b0);
    send_imm("R11 imm rot 4",   8'h80, 4'h4, 1'b1);
    idle();
    idle();
    // R1: no strobe, no result
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 idle strobe: actual %b expected 0", out_valid);
    end
    repeat (2) idle();
    checks++;
    if (q_val.size() != 0) begin
      failures++;
      $display("FAIL R1 missing results: actual %0d pending expected 0", q_val.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule